// File: doc/BRIEF.md
# AUX Burst Transfer Sequencer

This block carries out one native AUX read or write of any length against a sink's configuration address space. It cuts the transfer into bursts of at most sixteen bytes. For each burst it drives a lower-level AUX request engine. The engine owns a sixteen-byte data buffer, a 20-bit address presented as three fields, a command byte, a start strobe and a busy flag. The engine answers with a reply-received level, an error flag and a status nibble. Write bytes enter on a valid/ready byte stream. Read bytes leave on a valid-only byte stream once their burst has succeeded.

Each burst is attempted up to a fixed number of times. An attempt fails on any of these:
- the engine's busy flag stays high too long after the start strobe;
- no reply arrives within the reply window;
- the error flag is raised;
- the reply status is nonzero.

If every attempt of a burst fails, the whole transfer is abandoned and a fail pulse is given. A transfer whose bursts all succeed ends with a done pulse. Both timeouts are stated in milliseconds and converted to cycles from a clock-rate parameter in kHz, so a bench can use small windows.

Top module: `aux_burst_seq`

## Requirements
- R1: Every burst moves min(remaining, 16) bytes. The burst length minus one is placed in command bits [7:4].
- R2: The engine address fields carry the current address: bits 7:0 on the low field, 15:8 on the middle field and 19:16 on the high field. The address advances by 16 only after a successful burst, never on a retry.
- R3: Command bit 3 is always 1, selecting a native transaction. Bit 0 is 1 for a read and 0 for a write. Bits 2:1 are 0.
- R4: A burst is attempted at most MAX_TRY (default 10) times. After the last failed attempt, fail pulses for one cycle, no further start strobe is issued and the rest of the transfer is dropped.
- R5: For writes, the burst's bytes are taken from the write stream once per burst. Before every attempt the engine buffer is cleared, the bytes are then copied into buffer slots 0..n-1, and only after that is the start strobe given. Bursts that succeeded before an abort stay committed.
- R6: For reads, buffer bytes are emitted on the read stream in address order, and only after a successful attempt. A failed attempt emits nothing.
- R7: If busy is still high 20*CLK_KHZ cycles after the start strobe, the attempt fails. For a read, the next start strobe then follows exactly 20*CLK_KHZ+3 cycles after the previous one.
- R8: If no reply is seen within 10*CLK_KHZ cycles after busy drops, the attempt fails. A seen reply is cleared with a one-cycle clear pulse.
- R9: A raised error flag fails the attempt and is cleared with a one-cycle clear pulse. A nonzero status nibble also fails the attempt.
- R10: A zero-length request pulses done in the cycle after it is taken and issues no start strobe.
- R11: Done and fail are exclusive one-cycle pulses. A request presented while a transfer is in progress is ignored.
- R12: After reset the block is idle: no busy, done, fail, start strobe, write-ready or read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Request strobe, taken when idle |
| xfer_write | input | 1 | 1 = write transfer, 0 = read |
| xfer_addr | input | 20 | Start address |
| xfer_len | input | LEN_W | Byte count |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle success pulse |
| xfer_fail | output | 1 | One-cycle abort pulse |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| eng_buf_clr | output | 1 | Clear engine data buffer |
| eng_buf_we | output | 1 | Write engine buffer slot |
| eng_buf_idx | output | 4 | Engine buffer slot index |
| eng_buf_wdata | output | 8 | Engine buffer write byte |
| eng_buf_rdata | input | 8 | Engine buffer byte at eng_buf_idx |
| eng_addr_lo | output | 8 | Address bits 7:0 |
| eng_addr_mid | output | 8 | Address bits 15:8 |
| eng_addr_hi | output | 4 | Address bits 19:16 |
| eng_cmd | output | 8 | Command byte |
| eng_start | output | 1 | Start strobe for one attempt |
| eng_busy | input | 1 | Engine busy/enable flag |
| eng_reply | input | 1 | Reply received, held until cleared |
| eng_reply_clr | output | 1 | Clear reply indication |
| eng_err | input | 1 | Error flag, held until cleared |
| eng_err_clr | output | 1 | Clear error flag |
| eng_status | input | 4 | Reply status, zero means good |

## Verification
The assertions rely on the engine following a few rules:
- it raises busy on the edge that takes the start strobe;
- it holds reply and error as levels until the sequencer clears them;
- its error flag and status nibble are valid in the cycle the reply is seen;
- it never raises a reply while the sequencer is not waiting for one.

The bench's engine model keeps to these rules. It injects faults only through the documented paths: a busy flag that never drops, a missing reply, an error flag and a nonzero status. It injects each one at a single attempt chosen by a fault queue.

// File: rtl/aux_seq_pkg.sv
// Shared constants and state type for the AUX burst sequencer.
package aux_seq_pkg;
    localparam int BURST_MAX     = 16;
    localparam int CMD_NATIVE_B  = 3;
    localparam int CMD_READ_B    = 0;

    typedef enum logic [3:0] {
        S_IDLE, S_FILL, S_CLEAR, S_LOAD, S_ISSUE, S_WAIT_EN,
        S_WAIT_RP, S_CHECK, S_UNLOAD, S_NEXT, S_RETRY
    } seq_state_t;
endpackage

// File: rtl/aux_chunk_len.sv
// Burst length picker: the smaller of the remaining count and the burst limit.
// Assumes BURST fits in BL_W bits.
module aux_chunk_len #(
    parameter int LEN_W = 16,
    parameter int BURST = 16,
    parameter int BL_W  = $clog2(BURST + 1)
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [BL_W-1:0]  chunk
);
    // Clamp the remaining count to one burst.
    always_comb begin
        if (remaining >= LEN_W'(BURST))
            chunk = BL_W'(BURST);
        else
            chunk = BL_W'(remaining);
    end
endmodule

// File: rtl/aux_wait_timer.sv
// Cycle counter for the two attempt windows. It counts while run is high and
// restarts when run is low or restart is high. expired marks the last cycle
// of the selected window. Assumes SHORT_LIM <= LONG_LIM and both are >= 1.
module aux_wait_timer #(
    parameter int SHORT_LIM = 10,
    parameter int LONG_LIM  = 20,
    parameter int CW        = $clog2(LONG_LIM + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic use_long,
    output logic expired
);
    logic [CW-1:0] cnt;

    // Window end for the selected limit.
    always_comb begin
        expired = run && (cnt == (use_long ? CW'(LONG_LIM - 1) : CW'(SHORT_LIM - 1)));
    end

    // Count the cycles spent in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + CW'(1);
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LONG_LIM));
endmodule

// File: rtl/aux_wr_store.sv
// Local store for one burst of write bytes, kept so every retry resends the
// same data. One write port and one combinational read port. No reset: every
// slot read is written earlier in the same burst.
module aux_wr_store #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Capture one stream byte.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Present the slot being copied to the engine.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/aux_burst_seq.sv
// AUX burst transfer sequencer. It splits a native AUX transfer into bursts
// of up to 16 bytes and runs each burst on the request engine, retrying
// failed attempts. Assumes the engine raises eng_busy on the edge that takes
// eng_start, and holds eng_reply and eng_err until they are cleared.
module aux_burst_seq
    import aux_seq_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int CLK_KHZ = 50000,
    parameter int MAX_TRY = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_write,
    input  logic [19:0]      xfer_addr,
    input  logic [LEN_W-1:0] xfer_len,
    output logic             xfer_busy,
    output logic             xfer_done,
    output logic             xfer_fail,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             eng_buf_clr,
    output logic             eng_buf_we,
    output logic [3:0]       eng_buf_idx,
    output logic [7:0]       eng_buf_wdata,
    input  logic [7:0]       eng_buf_rdata,
    output logic [7:0]       eng_addr_lo,
    output logic [7:0]       eng_addr_mid,
    output logic [3:0]       eng_addr_hi,
    output logic [7:0]       eng_cmd,
    output logic             eng_start,
    input  logic             eng_busy,
    input  logic             eng_reply,
    output logic             eng_reply_clr,
    input  logic             eng_err,
    output logic             eng_err_clr,
    input  logic [3:0]       eng_status
);
    localparam int EN_LIM = 20 * CLK_KHZ;
    localparam int RP_LIM = 10 * CLK_KHZ;
    localparam int BL_W   = $clog2(BURST_MAX + 1);
    localparam int IW     = $clog2(BURST_MAX);
    localparam int AT_W   = $clog2(MAX_TRY + 1);

    seq_state_t       state;
    logic [19:0]      addr;
    logic [LEN_W-1:0] rem;
    logic [BL_W-1:0]  blen;
    logic [BL_W-1:0]  idx;
    logic [AT_W-1:0]  attempt;
    logic             is_write;
    logic             done_r;
    logic             fail_r;
    logic             tmo;
    logic             attempt_bad;

    aux_chunk_len #(.LEN_W(LEN_W), .BURST(BURST_MAX), .BL_W(BL_W)) u_chunk (
        .remaining (rem),
        .chunk     (blen)
    );

    aux_wait_timer #(.SHORT_LIM(RP_LIM), .LONG_LIM(EN_LIM)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == S_WAIT_EN || state == S_WAIT_RP),
        .restart  (state == S_WAIT_EN && !eng_busy),
        .use_long (state == S_WAIT_EN),
        .expired  (tmo)
    );

    aux_wr_store #(.DEPTH(BURST_MAX), .IW(IW)) u_store (
        .clk   (clk),
        .we    (state == S_FILL && wr_valid),
        .waddr (idx[IW-1:0]),
        .wdata (wr_data),
        .raddr (idx[IW-1:0]),
        .rdata (eng_buf_wdata)
    );

    // Attempt verdict taken in the reply-check cycle.
    always_comb attempt_bad = eng_err || (eng_status != 4'd0);

    // Sequence bursts and attempts, and track address, count and outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            addr     <= '0;
            rem      <= '0;
            idx      <= '0;
            attempt  <= '0;
            is_write <= 1'b0;
            done_r   <= 1'b0;
            fail_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            fail_r <= 1'b0;
            case (state)
                S_IDLE: if (xfer_start) begin
                    addr     <= xfer_addr;
                    rem      <= xfer_len;
                    is_write <= xfer_write;
                    attempt  <= '0;
                    idx      <= '0;
                    if (xfer_len == '0)
                        done_r <= 1'b1;
                    else
                        state <= xfer_write ? S_FILL : S_CLEAR;
                end
                S_FILL: if (wr_valid) begin
                    if (idx == blen - BL_W'(1)) begin
                        idx   <= '0;
                        state <= S_CLEAR;
                    end else begin
                        idx <= idx + BL_W'(1);
                    end
                end
                S_CLEAR: begin
                    idx   <= '0;
                    state <= is_write ? S_LOAD : S_ISSUE;
                end
                S_LOAD: begin
                    if (idx == blen - BL_W'(1)) begin
                        idx   <= '0;
                        state <= S_ISSUE;
                    end else begin
                        idx <= idx + BL_W'(1);
                    end
                end
                S_ISSUE:   state <= S_WAIT_EN;
                S_WAIT_EN: begin
                    if (!eng_busy)
                        state <= S_WAIT_RP;
                    else if (tmo)
                        state <= S_RETRY;
                end
                S_WAIT_RP: begin
                    if (eng_reply)
                        state <= S_CHECK;
                    else if (tmo)
                        state <= S_RETRY;
                end
                S_CHECK: begin
                    idx <= '0;
                    if (attempt_bad)
                        state <= S_RETRY;
                    else
                        state <= is_write ? S_NEXT : S_UNLOAD;
                end
                S_UNLOAD: begin
                    if (idx == blen - BL_W'(1)) begin
                        idx   <= '0;
                        state <= S_NEXT;
                    end else begin
                        idx <= idx + BL_W'(1);
                    end
                end
                S_NEXT: begin
                    attempt <= '0;
                    rem     <= rem - LEN_W'(blen);
                    addr    <= addr + 20'd16;
                    if (rem == LEN_W'(blen)) begin
                        done_r <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        state <= is_write ? S_FILL : S_CLEAR;
                    end
                end
                S_RETRY: begin
                    if (attempt == AT_W'(MAX_TRY - 1)) begin
                        fail_r <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        attempt <= attempt + AT_W'(1);
                        state   <= S_CLEAR;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the engine and stream outputs from the current state.
    always_comb begin
        xfer_busy     = (state != S_IDLE);
        xfer_done     = done_r;
        xfer_fail     = fail_r;
        wr_ready      = (state == S_FILL);
        rd_valid      = (state == S_UNLOAD);
        rd_data       = eng_buf_rdata;
        eng_buf_clr   = (state == S_CLEAR);
        eng_buf_we    = (state == S_LOAD);
        eng_buf_idx   = idx[IW-1:0];
        eng_addr_lo   = addr[7:0];
        eng_addr_mid  = addr[15:8];
        eng_addr_hi   = addr[19:16];
        eng_cmd       = '0;
        eng_cmd[7:4]  = 4'(blen - BL_W'(1));
        eng_cmd[CMD_NATIVE_B] = 1'b1;
        eng_cmd[CMD_READ_B]   = ~is_write;
        eng_start     = (state == S_ISSUE);
        eng_reply_clr = (state == S_CHECK);
        eng_err_clr   = (state == S_CHECK) && eng_err;
    end

    p_burst_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (LEN_W'(eng_cmd[7:4]) + LEN_W'(1)) <= rem);
    p_retry_keeps_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RETRY) |=> $stable(addr));
    p_attempt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        attempt < AT_W'(MAX_TRY));
    p_read_only_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !is_write);
    p_reply_clr_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_reply_clr |-> $past(eng_reply));
    p_err_clr_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err_clr |-> eng_err);
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && xfer_fail));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> !(eng_start || wr_ready || rd_valid));
endmodule

// File: tb/aux_burst_seq_bench.sv
`timescale 1ns/1ps
module aux_burst_seq_bench;
    localparam int LEN_W   = 16;
    localparam int CLK_KHZ = 2;
    localparam int EN_CYC  = 20 * CLK_KHZ;
    localparam int RP_CYC  = 10 * CLK_KHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             xfer_start = 1'b0;
    logic             xfer_write = 1'b0;
    logic [19:0]      xfer_addr = '0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             xfer_busy, xfer_done, xfer_fail;
    logic             wr_valid = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             wr_ready, rd_valid;
    logic [7:0]       rd_data;
    logic             eng_buf_clr, eng_buf_we, eng_start, eng_reply_clr, eng_err_clr;
    logic [3:0]       eng_buf_idx, eng_addr_hi;
    logic [7:0]       eng_buf_wdata, eng_buf_rdata, eng_addr_lo, eng_addr_mid, eng_cmd;
    logic             eng_busy, eng_reply, eng_err;
    logic [3:0]       eng_status;

    aux_burst_seq #(.LEN_W(LEN_W), .CLK_KHZ(CLK_KHZ), .MAX_TRY(10)) u_aux_burst_seq (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_busy(xfer_busy),
        .xfer_done(xfer_done), .xfer_fail(xfer_fail), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .eng_buf_clr(eng_buf_clr), .eng_buf_we(eng_buf_we), .eng_buf_idx(eng_buf_idx),
        .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata),
        .eng_addr_lo(eng_addr_lo), .eng_addr_mid(eng_addr_mid), .eng_addr_hi(eng_addr_hi),
        .eng_cmd(eng_cmd), .eng_start(eng_start), .eng_busy(eng_busy),
        .eng_reply(eng_reply), .eng_reply_clr(eng_reply_clr), .eng_err(eng_err),
        .eng_err_clr(eng_err_clr), .eng_status(eng_status)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'hA};
    endfunction

    // Engine model: buffer, sink memory, busy/reply timing and fault injection.
    logic [7:0] ebuf [16];
    logic [7:0] sink_mem [int];
    logic [7:0] ref_mem [int];
    int fault_q[$];
    int cur_mode = 0;
    int bcnt = 0;
    int rcnt = 0;
    bit rp_pending = 0;
    int n_err_clr = 0;
    int st_cyc[$];
    logic [19:0] st_addr[$];
    logic [7:0]  st_cmd[$];

    function automatic logic [7:0] sink_rd(input int a);
        return sink_mem.exists(a) ? sink_mem[a] : dflt(a);
    endfunction
    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
    endfunction

    assign eng_buf_rdata = ebuf[eng_buf_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            eng_busy <= 1'b0; eng_reply <= 1'b0; eng_err <= 1'b0; eng_status <= 4'd0;
            rp_pending = 0;
        end else begin
            if (eng_buf_clr) for (int i = 0; i < 16; i++) ebuf[i] <= 8'h00;
            if (eng_buf_we) ebuf[eng_buf_idx] <= eng_buf_wdata;
            if (eng_reply_clr) eng_reply <= 1'b0;
            if (eng_err_clr) begin eng_err <= 1'b0; n_err_clr++; end
            if (eng_start) begin
                int a;
                int n;
                a = int'({eng_addr_hi, eng_addr_mid, eng_addr_lo});
                n = int'(eng_cmd[7:4]) + 1;
                cur_mode = (fault_q.size() > 0) ? fault_q.pop_front() : 0;
                st_cyc.push_back(cyc); st_addr.push_back(a[19:0]); st_cmd.push_back(eng_cmd);
                if (cur_mode == 0) begin
                    if (eng_cmd[0]) for (int i = 0; i < n; i++) ebuf[i] <= sink_rd((a + i) & 20'hFFFFF);
                    else for (int i = 0; i < n; i++) sink_mem[(a + i) & 20'hFFFFF] = ebuf[i];
                end
                eng_busy <= 1'b1; bcnt = 2; rp_pending = 0;
                eng_reply <= 1'b0; eng_err <= 1'b0; eng_status <= 4'd0;
            end else if (eng_busy && cur_mode != 1) begin
                if (bcnt == 0) begin eng_busy <= 1'b0; rp_pending = 1; rcnt = 2; end
                else bcnt--;
            end else if (rp_pending) begin
                if (rcnt == 0) begin
                    rp_pending = 0;
                    if (cur_mode != 2) begin
                        eng_reply  <= 1'b1;
                        eng_err    <= (cur_mode == 3);
                        eng_status <= (cur_mode == 4) ? 4'h2 : 4'h0;
                    end
                end else rcnt--;
            end
        end
    end

    // Scoreboard monitor: compare each read byte against the expected queue.
    logic [7:0] exp_q[$];
    int rd_seen = 0;
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            rd_seen++;
            if (exp_q.size() == 0) chk(0, "R6 read byte with none expected", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R6 read byte", rd_data, e);
            end
        end
    end

    // Write stream feeder.
    logic [7:0] wq[$];
    bit hs = 0;
    always @(negedge clk) begin
        if (hs) void'(wq.pop_front());
        if (wq.size() > 0) begin wr_valid = 1'b1; wr_data = wq[0]; end
        else wr_valid = 1'b0;
        hs = wr_valid && wr_ready;
    end

    // Driver: queue expectations, issue one transfer, wait for its outcome.
    task automatic run(input bit wr, input logic [19:0] a, input int len, input int commit,
                       input bit poke, output bit got_done, output bit got_fail, output int lat);
        if (!wr) for (int i = 0; i < commit; i++) exp_q.push_back(ref_rd((a + i) & 20'hFFFFF));
        else for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(i * 7 + a[7:0] + 3);
            wq.push_back(b);
            if (i < commit) ref_mem[(a + i) & 20'hFFFFF] = b;
        end
        @(negedge clk);
        xfer_start = 1'b1; xfer_write = wr; xfer_addr = a; xfer_len = LEN_W'(len);
        @(negedge clk);
        xfer_start = 1'b0;
        got_done = 0; got_fail = 0; lat = 1;
        for (int k = 0; k < 5000; k++) begin
            if (xfer_done || xfer_fail) begin got_done = xfer_done; got_fail = xfer_fail; break; end
            if (poke && k == 3) begin xfer_start = 1'b1; xfer_addr = 20'hABCDE; end
            if (poke && k == 4) xfer_start = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (!(got_done || got_fail)) chk(0, "R11 transfer outcome timeout", 0, 1);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit d, f;
        int lat, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xfer_busy && !xfer_done && !xfer_fail, "R12 idle outputs", {xfer_busy, xfer_done, xfer_fail}, 0);
        chk(!eng_start && !wr_ready && !rd_valid, "R12 engine/stream quiet", {eng_start, wr_ready, rd_valid}, 0);

        // R10 zero length
        base = st_addr.size();
        run(0, 20'h00100, 0, 0, 0, d, f, lat);
        chk(d && !f, "R10 zero-length done", {d, f}, 2);
        chk(lat == 1, "R10 zero-length latency", lat, 1);
        chk(st_addr.size() == base, "R10 no start strobe", st_addr.size() - base, 0);

        // R1 R2 R3 R11 single short read with an ignored request mid-way
        base = st_addr.size();
        run(0, 20'h12345, 5, 5, 1, d, f, lat);
        chk(d && !f, "R11 read done", {d, f}, 2);
        chk(st_addr.size() - base == 1, "R11 ignored request issued nothing", st_addr.size() - base, 1);
        chk(st_addr[base] == 20'h12345, "R2 address fields", st_addr[base], 20'h12345);
        chk(st_cmd[base] == 8'h49, "R1 R3 read command", st_cmd[base], 8'h49);
        chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
        chk(eng_reply == 1'b0, "R8 reply cleared", eng_reply, 0);

        // R1 R2 multi-burst read across a 64K boundary
        base = st_addr.size();
        run(0, 20'h0FFF8, 37, 37, 0, d, f, lat);
        chk(d, "R1 long read done", d, 1);
        chk(st_addr.size() - base == 3, "R1 burst count", st_addr.size() - base, 3);
        chk(st_addr[base + 1] == 20'h10008, "R2 second address", st_addr[base + 1], 20'h10008);
        chk(st_addr[base + 2] == 20'h10018, "R2 third address", st_addr[base + 2], 20'h10018);
        chk(st_cmd[base] == 8'hF9, "R1 full burst length", st_cmd[base], 8'hF9);
        chk(st_cmd[base + 2] == 8'h49, "R1 tail burst length", st_cmd[base + 2], 8'h49);

        // R3 R5 write then read back
        base = st_addr.size();
        run(1, 20'h00200, 20, 20, 0, d, f, lat);
        chk(d, "R5 write done", d, 1);
        chk(st_cmd[base] == 8'hF8, "R3 write command", st_cmd[base], 8'hF8);
        chk(st_cmd[base + 1] == 8'h38, "R3 tail write command", st_cmd[base + 1], 8'h38);
        chk(wq.size() == 0, "R5 stream fully taken", wq.size(), 0);
        run(0, 20'h00200, 20, 20, 0, d, f, lat);
        chk(d, "R5 read-back done", d, 1);

        // R9 R2 error flag retries
        base = st_addr.size();
        lat = n_err_clr;
        fault_q = '{3, 3};
        run(0, 20'h00300, 8, 8, 0, d, f, lat);
        chk(d, "R9 recover after errors", d, 1);
        chk(st_addr.size() - base == 3, "R9 attempts", st_addr.size() - base, 3);
        chk(st_addr[base + 2] == 20'h00300, "R2 no advance on retry", st_addr[base + 2], 20'h00300);

        // R7 enable timeout window
        base = st_addr.size();
        fault_q = '{1};
        run(0, 20'h00400, 4, 4, 0, d, f, lat);
        chk(d && st_addr.size() - base == 2, "R7 recover after busy stuck", st_addr.size() - base, 2);
        chk(st_cyc[base + 1] - st_cyc[base] == EN_CYC + 3, "R7 enable timeout gap",
            st_cyc[base + 1] - st_cyc[base], EN_CYC + 3);

        // R8 reply timeout window
        base = st_addr.size();
        fault_q = '{2};
        run(0, 20'h00500, 4, 4, 0, d, f, lat);
        chk(d && st_addr.size() - base == 2, "R8 recover after no reply", st_addr.size() - base, 2);
        chk(st_cyc[base + 1] - st_cyc[base] == RP_CYC + 7, "R8 reply timeout gap",
            st_cyc[base + 1] - st_cyc[base], RP_CYC + 7);

        // R9 nonzero status
        base = st_addr.size();
        fault_q = '{4};
        run(0, 20'h00600, 3, 3, 0, d, f, lat);
        chk(d && st_addr.size() - base == 2, "R9 status retry", st_addr.size() - base, 2);

        // R4 R6 exhaust retries on a read
        base = st_addr.size();
        lat = rd_seen;
        fault_q = '{3, 3, 3, 3, 3, 3, 3, 3, 3, 3};
        run(0, 20'h00700, 20, 0, 0, d, f, lat);
        chk(f && !d, "R4 abort pulse", {d, f}, 1);
        chk(st_addr.size() - base == 10, "R4 attempt limit", st_addr.size() - base, 10);
        repeat (50) @(negedge clk);
        chk(st_addr.size() - base == 10 && !xfer_busy, "R4 no start after abort", st_addr.size() - base, 10);
        chk(exp_q.size() == 0, "R6 nothing emitted on failure", exp_q.size(), 0);

        // R4 R5 write aborted in its second burst keeps the first committed
        fault_q = '{0, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3};
        run(1, 20'h00800, 32, 16, 0, d, f, lat);
        chk(f, "R4 write abort", f, 1);
        run(0, 20'h00800, 32, 32, 0, d, f, lat);
        chk(d && exp_q.size() == 0, "R5 partial commit read-back", exp_q.size(), 0);
        chk(n_err_clr > 0, "R9 error clear pulses", n_err_clr, 1);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule